// File: doc/BRIEF.md
# Shared Indicator and Pushbutton Pin Controller

This block drives one open-drain pin that serves as both a status LED and a pushbutton input. It splits time into two equal halves that repeat at a fixed low rate. In the drive half it may pull the pin low to light the LED. In the tristate half it releases the pin, turns on a pull-up and reads the button.

The LED shows the node's configuration state, which it takes from two status inputs. It is lit steadily when there is no valid application. It blinks with a two-second period when an application is present but the network configuration is missing. It is dark when both are valid. When the button is pressed and the press passes a short debounce, the block emits a single-cycle request that asks the node to broadcast its identifier and program name. The broadcast itself, and the storage of the two status flags, live elsewhere.

Top module: `svc_pin_mux`

## Requirements
- R1: After reset is released the pin starts in the tristate half. The halves alternate every H = CLK_HZ/(2*PHASE_HZ) clock cycles, and `pullup_en_o` is 1 in exactly the tristate halves.
- R2: `drv_low_o` is 0 in every cycle of a tristate half, so the drive and the pull-up are never on together.
- R3: With `app_valid_i` = 0, `drv_low_o` is 1 throughout every drive half.
- R4: With `app_valid_i` = 1 and `cfg_valid_i` = 0, the LED blinks. A frame is one tristate half plus one drive half, and each frame ends at the last tristate cycle. After t frame ends since reset, the drive halves light the pin when floor(t/PHASE_HZ) is odd and stay dark when it is even, so the LED starts dark.
- R5: With both status inputs at 1, `drv_low_o` stays 0.
- R6: The pin is sampled once per frame, on the last cycle of the tristate half, through a two-stage synchronizer. A low level seen only during drive halves has no effect on `id_req_o`.
- R7: After three consecutive frame samples read low (0 = pressed), `id_req_o` is 1 for exactly one cycle, the one right after the clock edge that takes the third low sample. Fewer than three lows in a row give no pulse.
- R8: A press gives one pulse however long it is held. The filter rearms only after a sample reads high, so two presses separated by a high sample give two pulses.
- R9: While `rst_ni` is low, `drv_low_o` = 0, `pullup_en_o` = 1 (tristate) and `id_req_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| app_valid_i | input | 1 | A valid application is present |
| cfg_valid_i | input | 1 | Network configuration is present |
| pin_i | input | 1 | Pin level as read back from the pad (0 = pressed) |
| drv_low_o | output | 1 | 1 pulls the open-drain pin low |
| pullup_en_o | output | 1 | 1 enables the pad pull-up (tristate half) |
| id_req_o | output | 1 | One-cycle request to broadcast the node ID |

## Verification
The phase outputs and the LED drive are combinational from the phase counter and the status inputs, so they are due in the same cycle as the edge that moves the counter. The bench counts edges since reset and predicts them every cycle from H and PHASE_HZ. The request is registered and is due in the cycle after the frame-end edge that takes the third low sample. The bench changes the pin level only just after a frame end, so the synchronizer latency falls inside a stable frame, and it compares `id_req_o` on every falling clock edge against a model that is advanced only at frame-end edges.

// File: rtl/svc_pin_pkg.sv
package svc_pin_pkg;
  typedef enum logic {PH_TRI = 1'b0, PH_DRV = 1'b1} phase_e;
  typedef enum logic [1:0] {LED_ON, LED_BLINK, LED_OFF} led_sel_e;
endpackage

// File: rtl/svc_phase_gen.sv
module svc_phase_gen
  import svc_pin_pkg::*;
#(
  parameter int unsigned HALF_CYC = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o,
  output logic   tick_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;
  phase_e        phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= PH_TRI;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= (phase_q == PH_TRI) ? PH_DRV : PH_TRI;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  // frame end: last cycle of the tristate half
  assign tick_o  = (phase_q == PH_TRI) && (cnt_q == LAST);

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> (phase_q == $past(phase_q)));
  a_r1_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/svc_blink_gen.sv
module svc_blink_gen #(
  parameter int unsigned FRAMES = 76
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic blink_o
);
  localparam int unsigned BW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam logic [BW-1:0] LAST = BW'(FRAMES - 1);

  logic [BW-1:0] fcnt_q;
  logic          blink_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q  <= '0;
      blink_q <= 1'b0;
    end else if (tick_i) begin
      if (fcnt_q == LAST) begin
        fcnt_q  <= '0;
        blink_q <= ~blink_q;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  assign blink_o = blink_q;

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(blink_q));
endmodule

// File: rtl/svc_btn_filter.sv
module svc_btn_filter #(
  parameter int unsigned NSAMP = 3,
  parameter int unsigned NSYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic req_o
);
  logic [NSYNC-1:0] sync_q;
  logic [NSAMP-1:0] hist_q;
  logic             armed_q;
  logic             req_q;
  logic [NSAMP-1:0] hist_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[NSYNC-2:0], pin_i};
  end

  generate
    if (NSAMP > 1) begin : g_shift
      assign hist_d = {hist_q[NSAMP-2:0], sync_q[NSYNC-1]};
    end else begin : g_single
      assign hist_d = sync_q[NSYNC-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '1;
      armed_q <= 1'b1;
      req_q   <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (tick_i) begin
        hist_q <= hist_d;
        if (hist_d == '0 && armed_q) begin
          req_q   <= 1'b1;
          armed_q <= 1'b0;
        end else if (sync_q[NSYNC-1]) begin
          armed_q <= 1'b1;
        end
      end
    end
  end

  assign req_o = req_q;

  a_r8_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  a_r7_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(tick_i));
endmodule

// File: rtl/svc_pin_mux.sv
module svc_pin_mux
  import svc_pin_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 10_000_000,
  parameter int unsigned PHASE_HZ = 76,
  parameter int unsigned NSAMP    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic app_valid_i,
  input  logic cfg_valid_i,
  input  logic pin_i,
  output logic drv_low_o,
  output logic pullup_en_o,
  output logic id_req_o
);
  localparam int unsigned HALF_CYC = CLK_HZ / (2 * PHASE_HZ);
  localparam int unsigned FRAMES   = PHASE_HZ;  // one blink half = one second

  phase_e   phase;
  logic     tick;
  logic     blink;
  led_sel_e led_sel;
  logic     led_on;

  svc_phase_gen #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase),
    .tick_o (tick)
  );

  svc_blink_gen #(.FRAMES(FRAMES)) u_blink (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .blink_o(blink)
  );

  svc_btn_filter #(.NSAMP(NSAMP), .NSYNC(2)) u_btn (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .pin_i (pin_i),
    .req_o (id_req_o)
  );

  always_comb begin
    if (!app_valid_i)      led_sel = LED_ON;
    else if (!cfg_valid_i) led_sel = LED_BLINK;
    else                   led_sel = LED_OFF;
    unique case (led_sel)
      LED_ON:    led_on = 1'b1;
      LED_BLINK: led_on = blink;
      default:   led_on = 1'b0;
    endcase
  end

  assign drv_low_o   = (phase == PH_DRV) && led_on;
  assign pullup_en_o = (phase == PH_TRI);

  a_r2_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_low_o && pullup_en_o));
  a_r5_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (app_valid_i && cfg_valid_i) |-> !drv_low_o);
  a_r3_lit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!app_valid_i && !pullup_en_o) |-> drv_low_o);
endmodule

// File: tb/svc_pin_mux_tb.sv
module svc_pin_mux_tb;
  localparam int unsigned CLK_HZ   = 1216;
  localparam int unsigned PHASE_HZ = 76;
  localparam int unsigned H        = CLK_HZ / (2 * PHASE_HZ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic app = 1'b0, cfg = 1'b0, pin = 1'b1;
  logic drv, pu, req;

  int checks = 0, fails = 0;
  int n = 0;
  int press_left = 0;
  bit glitch = 0;
  bit exp_req = 0;
  int pulses = 0;
  logic [2:0] m_hist = 3'b111;
  bit m_armed = 1;
  string req_tag = "R7";

  always #4 clk = ~clk;

  svc_pin_mux #(.CLK_HZ(CLK_HZ), .PHASE_HZ(PHASE_HZ), .NSAMP(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .app_valid_i(app), .cfg_valid_i(cfg),
    .pin_i(pin), .drv_low_o(drv), .pullup_en_o(pu), .id_req_o(req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, n, act, exp);
    end
  endtask

  task automatic model_tick(input bit s);
    m_hist = {m_hist[1:0], s};
    exp_req = 0;
    if (m_hist == 3'b000 && m_armed) begin
      exp_req = 1;
      m_armed = 0;
    end else if (s) m_armed = 1;
  endtask

  task automatic cyc();
    bit tri_ph, led, blink, exp_drv;
    int ticks;
    @(posedge clk);
    n++;
    exp_req = 0;
    if (n % (2 * H) == H) model_tick(glitch ? 1'b1 : pin);
    @(negedge clk);
    tri_ph = ((n / H) % 2) == 0;
    ticks = (n >= int'(H)) ? (n - H) / (2 * H) + 1 : 0;
    blink = ((ticks / PHASE_HZ) % 2) == 1;
    led = !app ? 1'b1 : (!cfg ? blink : 1'b0);
    exp_drv = !tri_ph && led;
    chk(pu == tri_ph, "R1", pu, tri_ph);
    chk(drv == exp_drv, tri_ph ? "R2" : (!app ? "R3" : (!cfg ? "R4" : "R5")), drv, exp_drv);
    chk(req == exp_req, req_tag, req, exp_req);
    if (req) pulses++;
    if (glitch) pin = ((n / H) % 2 == 1) ? 1'b0 : 1'b1;  // low only in drive halves (R6)
    else if (n % (2 * H) == H) begin
      if (press_left > 0) begin pin = 1'b0; press_left--; end
      else pin = 1'b1;
    end
  endtask

  task automatic run(input int c);
    for (int i = 0; i < c; i++) cyc();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(drv == 1'b0, "R9", drv, 0);
      chk(pu == 1'b1, "R9", pu, 1);
      chk(req == 1'b0, "R9", req, 0);
    end
    rst_n = 1'b1;
    n = 0; m_hist = 3'b111; m_armed = 1; exp_req = 0;
  endtask

  task automatic press_test(input int frames, input int exp_pulses, input string tag);
    req_tag = tag;
    pulses = 0;
    press_left = frames;
    run((frames + 5) * 2 * H);
    chk(pulses == exp_pulses, tag, pulses, exp_pulses);
  endtask

  initial begin
    app = 0; cfg = 0; pin = 1;
    do_reset();
    run(20 * H);                         // R3 steady lit
    app = 1; cfg = 0;
    run(5 * PHASE_HZ * 2 * H);           // R4 blink over several seconds
    app = 1; cfg = 1;
    run(20 * H);                         // R5 dark
    app = 0; cfg = 1;
    press_test(2, 0, "R7");              // too short
    press_test(3, 1, "R7");              // minimum press
    press_test(12, 1, "R8");             // long hold, one pulse
    // two presses split by one high frame
    req_tag = "R8"; pulses = 0;
    press_left = 4; run(6 * 2 * H);
    press_left = 4; run(8 * 2 * H);
    chk(pulses == 2, "R8", pulses, 2);
    // low only during drive halves
    req_tag = "R6"; pulses = 0; glitch = 1;
    run(10 * 2 * H);
    glitch = 0; pin = 1;
    run(4 * 2 * H);
    chk(pulses == 0, "R6", pulses, 0);
    // reset while pressed
    press_left = 20; req_tag = "R9";
    run(2 * 2 * H);
    pin = 0; press_left = 0;
    do_reset();
    pin = 1; app = 1; cfg = 0;
    run(3 * PHASE_HZ * 2 * H);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog cycle=%0d actual=0 expected=1", n);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule